// File: doc/BRIEF.md
# SDLC Frame Address Filter

This block sits behind flag detection in a bit-oriented, flag-delimited receiver. Each received byte arrives with a tag: the first byte after an opening flag (the address byte), a byte inside the frame, or the closing flag. The block compares only the address byte against the programmed station address and against the broadcast value 0xFF. It then tells the receive FIFO, byte by byte, whether the byte may be stored. A frame whose address misses is dropped in full until the next frame begins.

A second output tells the interrupt logic whether receive interrupts may be raised. With filtering active, interrupts stay blocked unless the current frame's address matched. When the receiver is not in the flag-delimited mode, or when address search is switched off, every frame byte passes and interrupts are always allowed. Flag detection, zero-bit deletion and CRC are handled elsewhere.

Top module: `sdlc_addr_filter`

## Requirements
- R1: Filtering is active only when `mode_sdlc`=1 and `search_en`=1. Otherwise (bypass) every valid first or data byte without abort gives `byte_pass`=1 in the same cycle, `irq_allow` is 1, and the frame state returns to idle.
- R2: Tag encoding on `byte_kind`: 00 is the first byte, 01 a data byte, 10 the closing flag, 11 reserved. With filtering active, a first byte equal to `station_addr` gives `byte_pass`=1 in the same cycle and accepts the frame.
- R3: With filtering active, a first byte of 0xFF always matches, whatever `station_addr` holds.
- R4: With filtering active, a first byte that matches neither value gives `byte_pass`=0. Every data byte after it gives `byte_pass`=0 until a closing flag or abort.
- R5: With filtering active, `irq_allow` is 1 only while the frame is accepted. It rises in the cycle after a matching first byte and stays 0 after a miss.
- R6: A closing flag never passes. In the cycle after it the frame state is idle, with `irq_allow`=0 under filtering.
- R7: `rx_abort` drops any byte presented in the same cycle and returns the frame state to idle in the next cycle.
- R8: With filtering active, a data byte that arrives while no frame has been opened by a first byte gives `byte_pass`=0.
- R9: A byte tagged 11 never passes and leaves the frame state unchanged.
- R10: The accept or reject decision is taken on the first byte and is kept for every data byte up to the closing flag. A later first byte starts a new comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sdlc | input | 1 | Receiver is in the flag-delimited mode |
| search_en | input | 1 | Address search enable |
| station_addr | input | W | Programmed station address |
| byte_valid | input | 1 | A tagged byte is presented this cycle |
| byte_kind | input | 2 | Byte tag (see R2) |
| byte_data | input | W | Received byte |
| rx_abort | input | 1 | Abort sequence seen |
| byte_pass | output | 1 | Byte may be written to the receive FIFO |
| irq_allow | output | 1 | Receive interrupts permitted |

## Verification
Every address byte value is swept against several station addresses, including 0xFF and 0x00. This catches a comparator that misses a bit, ignores the broadcast value or matches broadcast by accident. Each swept frame is followed through its data bytes and closing flag. A design that kept the decision past the flag would leak data or interrupts into the next frame, and one that looked at each data byte separately would pass bytes of rejected frames. Further cases cover the bypass modes, an abort in the middle of a frame, a data byte with no opening address, reserved tags and switching search on in the middle of a frame. These expose a filter that works from stale state.

// File: rtl/sdlc_af_pkg.sv
package sdlc_af_pkg;

    typedef enum logic [1:0] {
        KIND_FIRST = 2'b00,
        KIND_DATA  = 2'b01,
        KIND_CLOSE = 2'b10,
        KIND_RSVD  = 2'b11
    } byte_kind_e;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'b00,
        FR_ACCEPT = 2'b01,
        FR_REJECT = 2'b10
    } frame_st_e;

    typedef struct packed {
        frame_st_e st;
    } ctrl_state_t;

endpackage

// File: rtl/sdlc_af_match.sv
module sdlc_af_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] addr_i,
    output logic         hit_o
);
    logic [W-1:0] eq_bits;
    logic [W-1:0] ones_bits;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign eq_bits[i]   = ~(data_i[i] ^ addr_i[i]);
        assign ones_bits[i] = data_i[i];
    end

    assign hit_o = (&eq_bits) | (&ones_bits);
endmodule

// File: rtl/sdlc_af_ctrl.sv
module sdlc_af_ctrl
    import sdlc_af_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bypass_i,
    input  logic       valid_i,
    input  logic [1:0] kind_i,
    input  logic       abort_i,
    input  logic       hit_i,
    output logic       pass_o,
    output logic       irq_o
);
    ctrl_state_t st_d, st_q;
    logic        is_byte;

    always_comb begin
        st_d    = st_q;
        pass_o  = 1'b0;
        is_byte = valid_i && (kind_i == KIND_FIRST || kind_i == KIND_DATA);
        if (bypass_i) begin
            st_d.st = FR_IDLE;
            pass_o  = is_byte && !abort_i;
        end else if (abort_i) begin
            st_d.st = FR_IDLE;
        end else if (valid_i) begin
            unique case (byte_kind_e'(kind_i))
                KIND_FIRST: begin
                    st_d.st = hit_i ? FR_ACCEPT : FR_REJECT;
                    pass_o  = hit_i;
                end
                KIND_DATA:  pass_o  = (st_q.st == FR_ACCEPT);
                KIND_CLOSE: st_d.st = FR_IDLE;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: FR_IDLE};
        else        st_q <= st_d;
    end

    assign irq_o = bypass_i || (st_q.st == FR_ACCEPT);
endmodule

// File: rtl/sdlc_addr_filter.sv
module sdlc_addr_filter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_sdlc,
    input  logic         search_en,
    input  logic [W-1:0] station_addr,
    input  logic         byte_valid,
    input  logic [1:0]   byte_kind,
    input  logic [W-1:0] byte_data,
    input  logic         rx_abort,
    output logic         byte_pass,
    output logic         irq_allow
);
    logic bypass;
    logic hit;

    assign bypass = !(mode_sdlc && search_en);

    sdlc_af_match #(.W(W)) match_i (
        .data_i (byte_data),
        .addr_i (station_addr),
        .hit_o  (hit)
    );

    sdlc_af_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass_i (bypass),
        .valid_i  (byte_valid),
        .kind_i   (byte_kind),
        .abort_i  (rx_abort),
        .hit_i    (hit),
        .pass_o   (byte_pass),
        .irq_o    (irq_allow)
    );
endmodule

// File: rtl/sdlc_af_chk.sv
module sdlc_af_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_sdlc,
    input logic         search_en,
    input logic [W-1:0] station_addr,
    input logic         byte_valid,
    input logic [1:0]   byte_kind,
    input logic [W-1:0] byte_data,
    input logic         rx_abort,
    input logic         byte_pass,
    input logic         irq_allow
);
    logic filt;
    logic first_ok;
    logic is_hit;
    assign filt     = mode_sdlc && search_en;
    assign first_ok = filt && byte_valid && !rx_abort && byte_kind == 2'b00;
    assign is_hit   = (byte_data == station_addr) || (byte_data == {W{1'b1}});

    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!filt && byte_valid && !rx_abort && !byte_kind[1]) |-> (byte_pass && irq_allow));

    p_station_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (first_ok && byte_data == station_addr) |-> byte_pass);

    p_bcast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (first_ok && byte_data == {W{1'b1}}) |-> byte_pass);

    p_miss_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (first_ok && !is_hit) |-> !byte_pass);

    p_irq_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (first_ok && !is_hit) |=> (!(mode_sdlc && search_en) || !irq_allow));

    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (first_ok && is_hit) |=> irq_allow);

    p_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_kind == 2'b10) |-> !byte_pass);

    p_close_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (filt && byte_valid && !rx_abort && byte_kind == 2'b10)
        |=> (!(mode_sdlc && search_en) || !irq_allow));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort |-> !byte_pass);

    p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_kind == 2'b11) |-> !byte_pass);
endmodule

bind sdlc_addr_filter sdlc_af_chk #(.W(W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sdlc    (mode_sdlc),
    .search_en    (search_en),
    .station_addr (station_addr),
    .byte_valid   (byte_valid),
    .byte_kind    (byte_kind),
    .byte_data    (byte_data),
    .rx_abort     (rx_abort),
    .byte_pass    (byte_pass),
    .irq_allow    (irq_allow)
);

// File: tb/sdlc_addr_filter_tb.sv
module sdlc_addr_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_sdlc = 1'b0;
    logic         search_en = 1'b0;
    logic [W-1:0] station_addr = '0;
    logic         byte_valid = 1'b0;
    logic [1:0]   byte_kind = 2'b00;
    logic [W-1:0] byte_data = '0;
    logic         rx_abort = 1'b0;
    logic         byte_pass;
    logic         irq_allow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int mst    = 0;   // 0 idle, 1 accept, 2 reject

    always #(CLK_PERIOD/2) clk = ~clk;

    sdlc_addr_filter #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sdlc(mode_sdlc), .search_en(search_en),
        .station_addr(station_addr), .byte_valid(byte_valid), .byte_kind(byte_kind),
        .byte_data(byte_data), .rx_abort(rx_abort), .byte_pass(byte_pass),
        .irq_allow(irq_allow)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [W-1:0] d, input logic ab, input string req);
        logic byp, hit, ep;
        @(negedge clk);
        byte_valid = 1'b1; byte_kind = k; byte_data = d; rx_abort = ab;
        byp = !(mode_sdlc && search_en);
        hit = (d == station_addr) || (d == 8'hFF);
        ep  = 1'b0;
        if (byp) begin
            ep = !ab && (k == 2'b00 || k == 2'b01);
            mst = 0;
        end else if (ab) begin
            mst = 0;
        end else if (k == 2'b00) begin
            ep = hit; mst = hit ? 1 : 2;
        end else if (k == 2'b01) begin
            ep = (mst == 1);
        end else if (k == 2'b10) begin
            mst = 0;
        end
        #1 check(req, "byte_pass", byte_pass, ep);
        @(posedge clk);
        #1;
        byte_valid = 1'b0; rx_abort = 1'b0;
        check(req, "irq_allow", irq_allow, byp || mst == 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] addrs [4];
        addrs[0] = 8'h00; addrs[1] = 8'h5A; addrs[2] = 8'hC3; addrs[3] = 8'hFF;

        repeat (3) @(posedge clk);
        #1 check("R1", "reset byte_pass", byte_pass, 1'b0);
        check("R1", "reset irq_allow bypass", irq_allow, 1'b1);
        rst_n = 1'b1;

        // R1: bypass, not in flag-delimited mode
        mode_sdlc = 1'b0; search_en = 1'b1; station_addr = 8'h12;
        send(2'b00, 8'h34, 1'b0, "R1");
        send(2'b01, 8'h56, 1'b0, "R1");
        send(2'b10, 8'h7E, 1'b0, "R6");
        // R1: bypass, search off
        mode_sdlc = 1'b1; search_en = 1'b0;
        send(2'b00, 8'h99, 1'b0, "R1");
        send(2'b01, 8'h01, 1'b0, "R1");
        send(2'b01, 8'h02, 1'b1, "R7");

        // R2 R3 R4 R5 R6 R10: full address sweep
        search_en = 1'b1;
        for (int a = 0; a < 4; a++) begin
            station_addr = addrs[a];
            for (int b = 0; b < 256; b++) begin
                send(2'b00, W'(b), 1'b0, (W'(b) == 8'hFF) ? "R3" : ((W'(b) == addrs[a]) ? "R2" : "R4"));
                send(2'b01, W'(b + 1), 1'b0, "R10");
                send(2'b01, W'(b + 7), 1'b0, "R4");
                send(2'b10, 8'h7E, 1'b0, "R6");
                send(2'b01, 8'h11, 1'b0, "R8");
            end
        end

        // R7: abort mid accepted frame
        station_addr = 8'h42;
        send(2'b00, 8'h42, 1'b0, "R2");
        send(2'b01, 8'h10, 1'b0, "R5");
        send(2'b01, 8'h20, 1'b1, "R7");
        send(2'b01, 8'h30, 1'b0, "R7");

        // R9: reserved tag keeps state
        send(2'b00, 8'hFF, 1'b0, "R3");
        send(2'b11, 8'h42, 1'b0, "R9");
        send(2'b01, 8'h55, 1'b0, "R9");
        send(2'b00, 8'h13, 1'b0, "R4");
        send(2'b11, 8'h42, 1'b0, "R9");
        send(2'b01, 8'h55, 1'b0, "R9");

        // R10: new first byte re-compares without closing flag
        send(2'b00, 8'h42, 1'b0, "R10");
        send(2'b01, 8'h66, 1'b0, "R10");

        // R1 R8: search switched on mid frame starts idle
        search_en = 1'b0;
        send(2'b00, 8'h01, 1'b0, "R1");
        search_en = 1'b1;
        send(2'b01, 8'h02, 1'b0, "R8");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule